// File: doc/BRIEF.md
# Block Transfer Capture Unit

This unit sits behind a serial decoder that has already removed line framing from a block transfer. The decoder hands it one event per cycle. An event is one of four kinds: a header that names a crate and a target slot, a 16-bit data item, an end marker with a cause code, or an error report. The unit can listen selectively, which means it takes a transfer only when the header matches a programmed crate and slot. It can also be set to take every transfer.

Accepted data items go into a local word buffer, in one of three formats. The unit counts the stored words and keeps a status byte. That byte shows whether a transfer is in flight, whether the buffer overflowed, any line errors, and why the last transfer ended. Stored words leave the unit in two ways. A host can read them one at a time through a small register bus that returns a Q/X response. A ready/acknowledge port can also take them. Both paths are gated by a data-ready enable and by the transfer being over.

The buffer holds 2**AW words. Setting AW=13 gives the full 8192-word capacity. The default is kept small so that elaboration stays light.

Top module: `bt_capture`

## Requirements
- R1: After reset, the word count, the status byte and the buffer are all cleared. Bus writes with function 16 and sub-address 0, 2 or 3 clear the same things. A write with function 16 and sub-address 1 does not clear them. The control and desired-address registers are not changed by these initializes.
- R2: Receive-all is control bit 8. When it is 0, a header event (ev_kind 0) starts a transfer only if ev_data[15:8] equals the desired crate and ev_data[4:0] equals the desired slot. A rejected transfer stores nothing and sets no status bit. When receive-all is 1, every header is accepted.
- R3: The buffer takes 2**AW words. A data word that arrives while the buffer is full is discarded and sets the sticky overflow bit (status bit 6). The word count stops at 2**AW.
- R4: The received address (function 0, sub 1) reads back in the layout crate[15:8], zeros[7:5], slot[4:0]. The desired address (function 0, sub 2) uses the same layout. A desired-address write is function 16, sub 2. Bits 7:5 of the write data are ignored.
- R5: The control write is function 16, sub 1. Data-ready enable is bit 12, receive-all is bit 8 and the format is bits 1:0. In format 0 (one word), 1 (two word) and 3, each data event (ev_kind 1) stores ev_data as one entry, in arrival order. The word count (function 0, sub 0) equals the number of words stored.
- R6: In format 2 (packed byte), each pair of consecutive data events stores one word. The first event's ev_data[7:0] goes in bits 15:8 and the second event's low byte goes in bits 7:0. A lone byte left when a header or end event arrives is dropped.
- R7: The status byte is read with function 1, sub 0, in bits 7:0. Bit 7 is 1 from an accepted header until its end event (ev_kind 2). The end event sets exactly one cause bit and clears the other three. Cause 0 (word count) sets bit 3, cause 1 (no-Q) sets bit 2, cause 2 (remote timeout) sets bit 1 and cause 3 (command) sets bit 0. A normal end therefore reads 0x0008.
- R8: A word read (function 0, sub 3) returns Q=1 and the next stored word only when all three of these hold: data-ready enable is 1, no transfer is active, and an unread word remains. Otherwise the read returns Q=0 and the read position does not move.
- R9: Function 6, sub 0 returns 0x0049. Every defined access answers X=1, and Q=1 except as R8 states. An undefined function/sub pair answers Q=0 and X=0.
- R10: dr_ready is 1 exactly when the three R8 conditions hold, and dr_word then shows the next stored word. dr_ready is 0 whenever data-ready enable is 0. The word is held until dr_ack is sampled high together with dr_ready, and then the next word follows. If a bus word read is made in the same cycle, dr_ack is ignored.
- R11: An error event (ev_kind 3) during an accepted transfer sets sticky frame-error (status bit 5) from ev_data[0] and sticky timeout (status bit 4) from ev_data[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Decoder event strobe |
| ev_kind | input | 2 | Event kind: 0 header, 1 data, 2 end, 3 error |
| ev_data | input | 16 | Event payload (address, word, byte, cause or error flags) |
| bus_strobe | input | 1 | Host access strobe, one cycle |
| bus_func | input | 5 | Host function code |
| bus_sub | input | 2 | Host sub-address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered read data |
| bus_q | output | 1 | Registered Q response |
| bus_x | output | 1 | Registered X response |
| dr_ready | output | 1 | A stored word is offered |
| dr_word | output | 16 | Offered word |
| dr_ack | input | 1 | Consumer takes the offered word |

## Verification
Every host access is sampled on the edge where bus_strobe is high. Its response, and any register it writes or clears, is visible one cycle later. The bench samples that response at the falling edge after that clock. A data event is registered once in the format stage and written one edge later, so the word count moves two edges after the event. After each transfer the bench waits three idle cycles before it reads anything. When a word is consumed, the next word reaches the head of the buffer after one more edge. For that reason every bus task and every acknowledge leaves one idle cycle before the next access.

// File: rtl/bt_capture_pkg.sv
package bt_capture_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] ID_CODE = 16'h0049;

  typedef enum logic [1:0] {
    EV_HEAD = 2'd0,
    EV_DATA = 2'd1,
    EV_END  = 2'd2,
    EV_ERR  = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    FMT_ONE  = 2'd0,
    FMT_TWO  = 2'd1,
    FMT_BYTE = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [7:0] crate;
    logic [4:0] slot;
  } addr_t;

  typedef struct packed {
    logic line_active;
    logic mem_ovf;
    logic frame_err;
    logic rx_timeout;
    logic end_count;
    logic end_noq;
    logic end_remote;
    logic end_cmd;
  } status_t;

  function automatic logic [WORD_W-1:0] pack_addr(addr_t a);
    return {a.crate, 3'b000, a.slot};
  endfunction
endpackage

// File: rtl/bt_rx_tracker.sv
module bt_rx_tracker
  import bt_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [WORD_W-1:0] ev_data,
  input  logic              rall,
  input  addr_t             want,
  input  logic              ovf_hit,
  output logic              active,
  output logic              store_en,
  output logic              flush,
  output addr_t             rx_addr,
  output status_t           status
);
  logic       active_q, ovf_q, fe_q, to_q;
  logic [3:0] cause_q;
  logic       hdr_ok;
  logic [4:0] ev_unused;

  assign ev_unused = {ev_data[7:5], ev_data[1:0]};

  always_comb begin
    hdr_ok   = rall || ((ev_data[15:8] == want.crate) && (ev_data[4:0] == want.slot));
    store_en = ev_valid && (ev_kind == EV_DATA) && active_q;
    flush    = ev_valid && ((ev_kind == EV_HEAD) || (ev_kind == EV_END));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active_q <= 1'b0;
      ovf_q    <= 1'b0;
      fe_q     <= 1'b0;
      to_q     <= 1'b0;
      cause_q  <= 4'b0000;
      rx_addr  <= '0;
    end else begin
      if (ovf_hit) ovf_q <= 1'b1;
      if (ev_valid) begin
        unique case (ev_kind)
          EV_HEAD: begin
            active_q <= hdr_ok;
            if (hdr_ok) begin
              rx_addr.crate <= ev_data[15:8];
              rx_addr.slot  <= ev_data[4:0];
            end
          end
          EV_END: begin
            if (active_q) begin
              active_q <= 1'b0;
              cause_q  <= 4'b1000 >> ev_data[1:0];
            end
          end
          EV_ERR: begin
            if (active_q) begin
              fe_q <= fe_q | ev_data[0];
              to_q <= to_q | ev_data[1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign active = active_q;
  assign status = status_t'({active_q, ovf_q, fe_q, to_q, cause_q});
endmodule

// File: rtl/bt_word_packer.sv
module bt_word_packer
  import bt_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              flush,
  input  logic              in_v,
  input  logic [WORD_W-1:0] in_data,
  input  logic              byte_mode,
  output logic              out_v,
  output logic [WORD_W-1:0] out_data
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] hi_q;
  logic              half_v;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_v    <= 1'b0;
      half_v   <= 1'b0;
      hi_q     <= '0;
      out_data <= '0;
    end else begin
      out_v <= 1'b0;
      if (flush) begin
        half_v <= 1'b0;
      end else if (in_v) begin
        if (!byte_mode) begin
          out_v    <= 1'b1;
          out_data <= in_data;
        end else if (half_v) begin
          out_v    <= 1'b1;
          out_data <= {hi_q, in_data[HALF_W-1:0]};
          half_v   <= 1'b0;
        end else begin
          hi_q   <= in_data[HALF_W-1:0];
          half_v <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bt_word_store.sv
module bt_word_store
  import bt_capture_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_v,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              adv,
  output logic [AW:0]       level,
  output logic              avail,
  output logic [WORD_W-1:0] head,
  output logic              ovf_hit
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr;
  logic              full, do_wr, fresh;

  assign full    = (wr_ptr == (AW+1)'(DEPTH));
  assign do_wr   = wr_v && !full;
  assign ovf_hit = wr_v && full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
    head <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fresh  <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (adv)   rd_ptr <= rd_ptr + 1'b1;
      fresh <= !(adv || (do_wr && (wr_ptr == rd_ptr)));
    end
  end

  assign level = wr_ptr;
  assign avail = fresh && (wr_ptr != rd_ptr);
endmodule

// File: rtl/bt_host_port.sv
module bt_host_port
  import bt_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_strobe,
  input  logic [4:0]        bus_func,
  input  logic [1:0]        bus_sub,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              active,
  input  logic              avail,
  input  logic [WORD_W-1:0] head,
  input  logic [WORD_W-1:0] count_word,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] status_word,
  output logic              dre,
  output logic              rall,
  output logic [1:0]        fmt,
  output addr_t             want,
  output logic              init,
  output logic              word_try,
  output logic              take_word,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_q,
  output logic              bus_x
);
  logic              word_ok, is_wr;
  logic [WORD_W-1:0] resp;
  logic              resp_q, resp_x;
  logic [7:0]        wdata_unused;

  assign wdata_unused = {bus_wdata[15:13], bus_wdata[11:9], bus_wdata[7:6]};

  always_comb begin
    word_ok   = dre && !active && avail;
    is_wr     = bus_strobe && (bus_func == 5'd16);
    word_try  = bus_strobe && (bus_func == 5'd0) && (bus_sub == 2'd3);
    take_word = word_try && word_ok;
    init      = is_wr && (bus_sub != 2'd1);
    resp      = '0;
    resp_q    = 1'b1;
    resp_x    = 1'b1;
    unique case (bus_func)
      5'd0: begin
        unique case (bus_sub)
          2'd0: resp = count_word;
          2'd1: resp = rx_word;
          2'd2: resp = pack_addr(want);
          default: begin
            resp_q = word_ok;
            resp   = word_ok ? head : '0;
          end
        endcase
      end
      5'd1: begin
        if (bus_sub == 2'd0) resp = status_word;
        else begin
          resp_q = 1'b0;
          resp_x = 1'b0;
        end
      end
      5'd6: begin
        if (bus_sub == 2'd0) resp = ID_CODE;
        else begin
          resp_q = 1'b0;
          resp_x = 1'b0;
        end
      end
      5'd16: ;
      default: begin
        resp_q = 1'b0;
        resp_x = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dre       <= 1'b0;
      rall      <= 1'b0;
      fmt       <= FMT_ONE;
      want      <= '0;
      bus_rdata <= '0;
      bus_q     <= 1'b0;
      bus_x     <= 1'b0;
    end else if (bus_strobe) begin
      bus_rdata <= resp;
      bus_q     <= resp_q;
      bus_x     <= resp_x;
      if (is_wr && bus_sub == 2'd1) begin
        dre  <= bus_wdata[12];
        rall <= bus_wdata[8];
        fmt  <= bus_wdata[1:0];
      end
      if (is_wr && bus_sub == 2'd2) begin
        want.crate <= bus_wdata[15:8];
        want.slot  <= bus_wdata[4:0];
      end
    end
  end
endmodule

// File: rtl/bt_capture.sv
module bt_capture
  import bt_capture_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  input  logic [1:0]  ev_kind,
  input  logic [15:0] ev_data,
  input  logic        bus_strobe,
  input  logic [4:0]  bus_func,
  input  logic [1:0]  bus_sub,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_q,
  output logic        bus_x,
  output logic        dr_ready,
  output logic [15:0] dr_word,
  input  logic        dr_ack
);
  logic              dre, rall, init, word_try, take_word;
  logic [1:0]        fmt;
  addr_t             want, rx_addr;
  status_t           status;
  logic              active, store_en, flush, ovf_hit;
  logic              pk_v, avail, adv;
  logic [WORD_W-1:0] pk_data, head, wcount, status_word;
  logic [AW:0]       level;

  assign wcount      = WORD_W'(level);
  assign status_word = {8'h00, status};

  bt_host_port host_i (
    .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_func(bus_func),
    .bus_sub(bus_sub), .bus_wdata(bus_wdata), .active(active), .avail(avail),
    .head(head), .count_word(wcount), .rx_word(pack_addr(rx_addr)),
    .status_word(status_word), .dre(dre), .rall(rall), .fmt(fmt), .want(want),
    .init(init), .word_try(word_try), .take_word(take_word),
    .bus_rdata(bus_rdata), .bus_q(bus_q), .bus_x(bus_x)
  );

  bt_rx_tracker track_i (
    .clk(clk), .rst(rst), .clr(init), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_data(ev_data), .rall(rall), .want(want), .ovf_hit(ovf_hit),
    .active(active), .store_en(store_en), .flush(flush), .rx_addr(rx_addr),
    .status(status)
  );

  bt_word_packer pack_i (
    .clk(clk), .rst(rst), .clr(init), .flush(flush), .in_v(store_en),
    .in_data(ev_data), .byte_mode(fmt == FMT_BYTE), .out_v(pk_v),
    .out_data(pk_data)
  );

  bt_word_store #(.AW(AW)) store_i (
    .clk(clk), .rst(rst), .clr(init), .wr_v(pk_v), .wr_data(pk_data),
    .adv(adv), .level(level), .avail(avail), .head(head), .ovf_hit(ovf_hit)
  );

  assign dr_ready = dre && !active && avail;
  assign dr_word  = head;
  assign adv      = take_word || (dr_ack && dr_ready && !word_try);
endmodule

// File: rtl/bt_capture_chk.sv
module bt_capture_chk #(
  parameter int AW = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        dre,
  input logic        active,
  input logic        dr_ready,
  input logic [15:0] wcount,
  input logic [7:0]  status_word_lo,
  input logic        bus_q,
  input logic        bus_x
);
  localparam int DEPTH = 1 << AW;

  assert_ready_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    !dre |-> !dr_ready);

  assert_no_offer_while_active_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> !dr_ready);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    wcount <= 16'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(status_word_lo[6]) |-> ($past(wcount) == 16'(DEPTH)));

  assert_single_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(status_word_lo[3:0]) <= 1);

  assert_q_needs_x_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_x |-> !bus_q);
endmodule

bind bt_capture bt_capture_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .dre(dre), .active(active), .dr_ready(dr_ready),
  .wcount(wcount), .status_word_lo(status_word[7:0]), .bus_q(bus_q), .bus_x(bus_x)
);

// File: tb/bt_capture_tb_top.sv
module bt_capture_tb_top;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = 2'd0;
  logic [15:0] ev_data = 16'h0;
  logic        bus_strobe = 1'b0;
  logic [4:0]  bus_func = 5'd0;
  logic [1:0]  bus_sub = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_q, bus_x, dr_ready;
  logic [15:0] dr_word;
  logic        dr_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] r_data;
  logic        r_q, r_x;

  always #2.5 clk = ~clk;

  bt_capture #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data),
    .bus_strobe(bus_strobe), .bus_func(bus_func), .bus_sub(bus_sub),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_q(bus_q), .bus_x(bus_x),
    .dr_ready(dr_ready), .dr_word(dr_word), .dr_ack(dr_ack)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [4:0] f, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_strobe = 1'b1; bus_func = f; bus_sub = a; bus_wdata = d;
    @(negedge clk);
    bus_strobe = 1'b0;
    r_data = bus_rdata; r_q = bus_q; r_x = bus_x;
  endtask

  task automatic ev(input logic [1:0] k, input logic [15:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_data = d;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); dr_ack = 1'b1;
    @(negedge clk); dr_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R9 identity and undefined codes
    bus(5'd0, 2'd0, 0); check("R1 count", r_data, 16'h0000);
    bus(5'd1, 2'd0, 0); check("R1 status", r_data, 16'h0000);
    bus(5'd6, 2'd0, 0); check("R9 id", r_data, 16'h0049);
    check("R9 qx", {14'd0, r_q, r_x}, 16'h0003);
    bus(5'd5, 2'd0, 0); check("R9 undefined qx", {14'd0, r_q, r_x}, 16'h0000);
    bus(5'd1, 2'd1, 0); check("R9 undefined sub qx", {14'd0, r_q, r_x}, 16'h0000);
    check("R10 ready reset", {15'd0, dr_ready}, 16'h0000);

    // R4 address layout
    bus(5'd16, 2'd1, 16'h1000);
    bus(5'd16, 2'd2, 16'hA1FF);
    bus(5'd0, 2'd2, 0); check("R4 desired zero gap", r_data, 16'hA11F);
    bus(5'd16, 2'd2, 16'hA104);
    bus(5'd0, 2'd2, 0); check("R4 desired", r_data, 16'hA104);

    // R2 rejected transfer
    ev(2'd0, 16'hA204);
    for (int i = 0; i < 3; i++) ev(2'd1, 16'h5500 + 16'(i));
    ev(2'd2, 16'h0000);
    settle();
    bus(5'd0, 2'd0, 0); check("R2 reject count", r_data, 16'h0000);
    bus(5'd1, 2'd0, 0); check("R2 reject status", r_data, 16'h0000);

    // R7 active bit, R8 read while active, R5 one-word storage
    ev(2'd0, 16'hA104);
    bus(5'd1, 2'd0, 0); check("R7 active bit", r_data, 16'h0080);
    for (int i = 0; i < 5; i++) ev(2'd1, 16'h1000 + 16'(i) * 16'h0101);
    settle();
    bus(5'd0, 2'd3, 0); check("R8 no q while active", {15'd0, r_q}, 16'h0000);
    ev(2'd2, 16'h0000);
    settle();
    bus(5'd1, 2'd0, 0); check("R7 normal end", r_data, 16'h0008);
    bus(5'd0, 2'd0, 0); check("R5 count", r_data, 16'h0005);
    bus(5'd0, 2'd1, 0); check("R4 received addr", r_data, 16'hA104);
    for (int i = 0; i < 5; i++) begin
      bus(5'd0, 2'd3, 0);
      check("R5 word", r_data, 16'h1000 + 16'(i) * 16'h0101);
      check("R8 q", {15'd0, r_q}, 16'h0001);
    end
    bus(5'd0, 2'd3, 0); check("R8 empty q", {15'd0, r_q}, 16'h0000);
    bus(5'd0, 2'd0, 0); check("R8 count kept", r_data, 16'h0005);

    // R1 init via F16 A3 ; R10 handshake with enable gating
    bus(5'd16, 2'd3, 0);
    bus(5'd0, 2'd0, 0); check("R1 init count", r_data, 16'h0000);
    bus(5'd1, 2'd0, 0); check("R1 init status", r_data, 16'h0000);
    bus(5'd16, 2'd1, 16'h0000);
    ev(2'd0, 16'hA104);
    ev(2'd1, 16'h7E01); ev(2'd1, 16'h7E02);
    ev(2'd2, 16'h0000);
    settle();
    bus(5'd0, 2'd3, 0); check("R8 no q when disabled", {15'd0, r_q}, 16'h0000);
    check("R10 ready low when disabled", {15'd0, dr_ready}, 16'h0000);
    bus(5'd16, 2'd1, 16'h1000);
    check("R1 control write keeps count", 16'(dr_ready), 16'h0001);
    check("R10 first word", dr_word, 16'h7E01);
    ack();
    check("R10 second word", dr_word, 16'h7E02);
    check("R10 ready still", {15'd0, dr_ready}, 16'h0001);
    ack();
    check("R10 drained", {15'd0, dr_ready}, 16'h0000);

    // R7 cause sweep with receive-all (R2)
    bus(5'd16, 2'd1, 16'h1100);
    for (int c = 0; c < 4; c++) begin
      bus(5'd16, 2'd0, 0);
      ev(2'd0, 16'hBE07);
      ev(2'd1, 16'h0F00 + 16'(c));
      ev(2'd2, 16'(c));
      settle();
      bus(5'd1, 2'd0, 0); check("R7 cause", r_data, 16'h0008 >> c);
      bus(5'd0, 2'd0, 0); check("R2 receive all count", r_data, 16'h0001);
    end

    // R11 error flags
    bus(5'd16, 2'd1, 16'h1000);
    bus(5'd16, 2'd0, 0);
    ev(2'd3, 16'h0003);
    bus(5'd1, 2'd0, 0); check("R11 error ignored when idle", r_data, 16'h0000);
    ev(2'd0, 16'hA104);
    ev(2'd3, 16'h0001);
    bus(5'd1, 2'd0, 0); check("R11 frame", r_data, 16'h00A0);
    ev(2'd3, 16'h0002);
    ev(2'd2, 16'h0003);
    settle();
    bus(5'd1, 2'd0, 0); check("R11 sticky end", r_data, 16'h0031);

    // R6 packed bytes, R1 init via desired write
    bus(5'd16, 2'd1, 16'h1002);
    bus(5'd16, 2'd2, 16'hA104);
    bus(5'd1, 2'd0, 0); check("R1 desired write init", r_data, 16'h0000);
    ev(2'd0, 16'hA104);
    for (int i = 0; i < 5; i++) ev(2'd1, 16'hFF12 + 16'(i) * 16'h0022);
    ev(2'd2, 16'h0000);
    settle();
    bus(5'd0, 2'd0, 0); check("R6 packed count", r_data, 16'h0002);
    bus(5'd0, 2'd3, 0); check("R6 word0", r_data, 16'h1234);
    bus(5'd0, 2'd3, 0); check("R6 word1", r_data, 16'h5678);

    // R5 two-word mode
    bus(5'd16, 2'd1, 16'h1001);
    bus(5'd16, 2'd0, 0);
    ev(2'd0, 16'hA104);
    for (int i = 0; i < 4; i++) ev(2'd1, 16'h2200 + 16'(i));
    ev(2'd2, 16'h0000);
    settle();
    bus(5'd0, 2'd0, 0); check("R5 two word count", r_data, 16'h0004);
    for (int i = 0; i < 4; i++) begin
      bus(5'd0, 2'd3, 0); check("R5 two word entry", r_data, 16'h2200 + 16'(i));
    end

    // R3 overflow
    bus(5'd16, 2'd1, 16'h1000);
    bus(5'd16, 2'd0, 0);
    ev(2'd0, 16'hA104);
    for (int i = 0; i < DEPTH + 3; i++) ev(2'd1, 16'hC000 + 16'(i));
    ev(2'd2, 16'h0000);
    settle();
    bus(5'd0, 2'd0, 0); check("R3 saturated count", r_data, 16'(DEPTH));
    bus(5'd1, 2'd0, 0); check("R3 overflow status", r_data, 16'h0048);
    for (int i = 0; i < DEPTH; i++) begin
      bus(5'd0, 2'd3, 0); check("R3 kept word", r_data, 16'hC000 + 16'(i));
    end
    bus(5'd0, 2'd3, 0); check("R3 discarded", {15'd0, r_q}, 16'h0000);
    bus(5'd16, 2'd3, 0);
    bus(5'd1, 2'd0, 0); check("R1 overflow cleared", r_data, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule